// File: doc/BRIEF.md
# Back-to-Back MII Crosspoint

This block joins two MAC-facing media independent interfaces so that two MACs can exchange frames with no PHY between them. Each MAC sees the block as its own PHY. The receive bus presented to each MAC comes from one of three sources:

- the opposite MAC's transmit bus, in normal transfer;
- the MAC's own transmit bus, in loopback;
- a constant zero bus, when the link is held down.

The selection is decided jointly by the mode bits of both sides. Either MAC can therefore take the link down for both.

The block also produces carrier sense and collision for each side. In normal transfer, carrier sense follows that side's own transmit enable. In any test mode, carrier sense is forced high on both sides so that neither MAC starts a frame. Collision is raised only by a side's own collision-test bit. Every output is a combinational function of the present inputs. There is no clock and no state.

Each bus is packed as {error, enable, data}. The data nibble width is a parameter.

Top module: `b2b_mii_xpoint`

## Requirements
- R1: With no mode bit set on either side, side A's receive data, valid and error equal side B's transmit data, enable and error, and side B's receive bus equals side A's transmit bus.
- R2: If the power-down or isolate bit is set on either side, both receive buses (data, valid, error) are all zeros, whatever the other mode bits.
- R3: If neither side has power-down or isolate set and either side has loopback set, each side's receive bus equals its own transmit bus.
- R4: If the only mode bits set on either side are collision-test bits, both receive buses are all zeros.
- R5: `link_down` is 1 exactly when at least one of the eight mode bits (four per side) is set.
- R6: While `link_down` is 1, carrier sense is 1 on both sides, regardless of transmit enable.
- R7: While `link_down` is 0, each side's carrier sense equals that side's own transmit enable.
- R8: Each side's collision output equals that side's own collision-test bit. It is unaffected by the other side's bits, by the other mode bits and by transmit activity.
- R9: Every output settles within the same cycle as a change on the inputs. No clock edge is needed to update any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_txd | input | DATA_W | Side A transmit data nibble |
| a_tx_en | input | 1 | Side A transmit enable |
| a_tx_er | input | 1 | Side A transmit error |
| a_pwr_dn | input | 1 | Side A power-down mode bit |
| a_isolate | input | 1 | Side A isolate mode bit |
| a_loopback | input | 1 | Side A loopback mode bit |
| a_col_test | input | 1 | Side A collision-test mode bit |
| b_txd | input | DATA_W | Side B transmit data nibble |
| b_tx_en | input | 1 | Side B transmit enable |
| b_tx_er | input | 1 | Side B transmit error |
| b_pwr_dn | input | 1 | Side B power-down mode bit |
| b_isolate | input | 1 | Side B isolate mode bit |
| b_loopback | input | 1 | Side B loopback mode bit |
| b_col_test | input | 1 | Side B collision-test mode bit |
| a_rxd | output | DATA_W | Side A receive data nibble |
| a_rx_dv | output | 1 | Side A receive data valid |
| a_rx_er | output | 1 | Side A receive error |
| a_crs | output | 1 | Side A carrier sense |
| a_col | output | 1 | Side A collision |
| b_rxd | output | DATA_W | Side B receive data nibble |
| b_rx_dv | output | 1 | Side B receive data valid |
| b_rx_er | output | 1 | Side B receive error |
| b_crs | output | 1 | Side B carrier sense |
| b_col | output | 1 | Side B collision |
| link_down | output | 1 | 1 while any test mode is active on either side |

## Verification
Immediate assertions inside the RTL re-check, whenever an input changes, the relations between ports that do not depend on the mode priority:

- cross-connection when idle of modes;
- zero buses under power-down or isolate;
- forced carrier while the link is down;
- collision tracking its own test bit.

The chain of priorities among loopback, collision test and the zero source is shown only by the bench. It sweeps all 256 mode combinations against sixteen transmit patterns, which reach every source choice and both carrier-sense regimes. The claim that outputs need no clock edge (R9) is shown only by the bench's sampling: it drives inputs and reads the outputs half a cycle later, before any clock edge.

// File: rtl/b2b_mii_pkg.sv
package b2b_mii_pkg;

  // Which bus feeds a receive output
  typedef enum logic [1:0] {
    SRC_PEER = 2'd0,
    SRC_SELF = 2'd1,
    SRC_ZERO = 2'd2
  } rx_src_e;

  // Per-side mode request bits
  typedef struct packed {
    logic pwr_dn;
    logic isolate;
    logic loopback;
    logic col_test;
  } side_mode_t;

  localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/b2b_mii_mode_dec.sv
module b2b_mii_mode_dec
  import b2b_mii_pkg::*;
#(
  parameter int unsigned N_SIDES = NUM_SIDES
) (
  input  side_mode_t mode_i [N_SIDES],
  output rx_src_e    src_o,
  output logic       link_down_o
);

  logic any_kill;
  logic any_loop;
  logic any_ctst;

  always_comb begin
    any_kill = 1'b0;
    any_loop = 1'b0;
    any_ctst = 1'b0;
    for (int s = 0; s < int'(N_SIDES); s++) begin
      any_kill = any_kill | mode_i[s].pwr_dn | mode_i[s].isolate;
      any_loop = any_loop | mode_i[s].loopback;
      any_ctst = any_ctst | mode_i[s].col_test;
    end
  end

  // Priority: kill (zeros) > loopback > collision-test only (zeros) > peer
  always_comb begin
    if (any_kill)      src_o = SRC_ZERO;
    else if (any_loop) src_o = SRC_SELF;
    else if (any_ctst) src_o = SRC_ZERO;
    else               src_o = SRC_PEER;
  end

  assign link_down_o = any_kill | any_loop | any_ctst;

  always_comb begin
    // R5: peer routing only ever chosen with the link up
    p_peer_only_when_up_r5: assert (!(src_o == SRC_PEER && link_down_o))
      else $error("peer source selected while link down");
  end

endmodule

// File: rtl/b2b_mii_rx_sel.sv
module b2b_mii_rx_sel
  import b2b_mii_pkg::*;
#(
  parameter int unsigned BUS_W = 6
) (
  input  logic [BUS_W-1:0] own_tx_i,
  input  logic [BUS_W-1:0] peer_tx_i,
  input  rx_src_e          src_i,
  output logic [BUS_W-1:0] rx_o
);

  always_comb begin
    unique case (src_i)
      SRC_PEER: rx_o = peer_tx_i;
      SRC_SELF: rx_o = own_tx_i;
      default:  rx_o = '0;
    endcase
  end

endmodule

// File: rtl/b2b_mii_cs_col.sv
module b2b_mii_cs_col (
  input  logic tx_en_i,
  input  logic col_test_i,
  input  logic link_down_i,
  output logic crs_o,
  output logic col_o
);

  assign crs_o = link_down_i | tx_en_i;
  assign col_o = col_test_i;

endmodule

// File: rtl/b2b_mii_xpoint.sv
module b2b_mii_xpoint
  import b2b_mii_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_txd,
  input  logic              a_tx_en,
  input  logic              a_tx_er,
  input  logic              a_pwr_dn,
  input  logic              a_isolate,
  input  logic              a_loopback,
  input  logic              a_col_test,
  input  logic [DATA_W-1:0] b_txd,
  input  logic              b_tx_en,
  input  logic              b_tx_er,
  input  logic              b_pwr_dn,
  input  logic              b_isolate,
  input  logic              b_loopback,
  input  logic              b_col_test,
  output logic [DATA_W-1:0] a_rxd,
  output logic              a_rx_dv,
  output logic              a_rx_er,
  output logic              a_crs,
  output logic              a_col,
  output logic [DATA_W-1:0] b_rxd,
  output logic              b_rx_dv,
  output logic              b_rx_er,
  output logic              b_crs,
  output logic              b_col,
  output logic              link_down
);

  localparam int unsigned BUS_W = DATA_W + 2;
  localparam int unsigned EN_B  = DATA_W;
  localparam int unsigned ER_B  = DATA_W + 1;

  logic [BUS_W-1:0] tx_bus [NUM_SIDES];
  logic [BUS_W-1:0] rx_bus [NUM_SIDES];
  side_mode_t       mode   [NUM_SIDES];
  logic             crs_v  [NUM_SIDES];
  logic             col_v  [NUM_SIDES];
  rx_src_e          src;
  logic             ld;

  assign tx_bus[0] = {a_tx_er, a_tx_en, a_txd};
  assign tx_bus[1] = {b_tx_er, b_tx_en, b_txd};
  assign mode[0]   = '{pwr_dn: a_pwr_dn, isolate: a_isolate,
                       loopback: a_loopback, col_test: a_col_test};
  assign mode[1]   = '{pwr_dn: b_pwr_dn, isolate: b_isolate,
                       loopback: b_loopback, col_test: b_col_test};

  b2b_mii_mode_dec #(.N_SIDES(NUM_SIDES)) u_dec (
    .mode_i      (mode),
    .src_o       (src),
    .link_down_o (ld)
  );

  for (genvar s = 0; s < int'(NUM_SIDES); s++) begin : g_side
    localparam int unsigned PEER = (s == 0) ? 1 : 0;

    b2b_mii_rx_sel #(.BUS_W(BUS_W)) u_sel (
      .own_tx_i  (tx_bus[s]),
      .peer_tx_i (tx_bus[PEER]),
      .src_i     (src),
      .rx_o      (rx_bus[s])
    );

    b2b_mii_cs_col u_cc (
      .tx_en_i     (tx_bus[s][EN_B]),
      .col_test_i  (mode[s].col_test),
      .link_down_i (ld),
      .crs_o       (crs_v[s]),
      .col_o       (col_v[s])
    );
  end

  assign a_rxd     = rx_bus[0][DATA_W-1:0];
  assign a_rx_dv   = rx_bus[0][EN_B];
  assign a_rx_er   = rx_bus[0][ER_B];
  assign b_rxd     = rx_bus[1][DATA_W-1:0];
  assign b_rx_dv   = rx_bus[1][EN_B];
  assign b_rx_er   = rx_bus[1][ER_B];
  assign a_crs     = crs_v[0];
  assign b_crs     = crs_v[1];
  assign a_col     = col_v[0];
  assign b_col     = col_v[1];
  assign link_down = ld;

  always_comb begin
    if (!ld) begin
      // R1: idle modes cross the buses over
      p_cross_a_r1: assert (rx_bus[0] == tx_bus[1])
        else $error("side A rx not fed by side B tx");
      p_cross_b_r1: assert (rx_bus[1] == tx_bus[0])
        else $error("side B rx not fed by side A tx");
      // R7: carrier follows own enable while link is up
      p_crs_own_r7: assert (crs_v[0] == tx_bus[0][EN_B] && crs_v[1] == tx_bus[1][EN_B])
        else $error("carrier sense not tracking own enable");
    end
    if (mode[0].pwr_dn | mode[0].isolate | mode[1].pwr_dn | mode[1].isolate) begin
      // R2: kill modes silence both receive buses
      p_kill_zero_r2: assert (rx_bus[0] == '0 && rx_bus[1] == '0)
        else $error("receive bus not zero under power-down/isolate");
    end
    if (ld) begin
      // R6: carrier forced on both sides while down
      p_crs_forced_r6: assert (crs_v[0] && crs_v[1])
        else $error("carrier sense low while link down");
    end
    // R8: collision mirrors own test bit only
    p_col_own_r8: assert (col_v[0] == mode[0].col_test && col_v[1] == mode[1].col_test)
      else $error("collision not tracking own test bit");
  end

endmodule

// File: tb/b2b_mii_xpoint_bench.sv
`timescale 1ns/1ps
module b2b_mii_xpoint_bench;

  localparam int DW = 4;
  localparam int BW = DW + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [DW-1:0] a_txd, b_txd, a_rxd, b_rxd;
  logic a_tx_en, a_tx_er, b_tx_en, b_tx_er;
  logic a_pwr_dn, a_isolate, a_loopback, a_col_test;
  logic b_pwr_dn, b_isolate, b_loopback, b_col_test;
  logic a_rx_dv, a_rx_er, a_crs, a_col;
  logic b_rx_dv, b_rx_er, b_crs, b_col, link_down;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  b2b_mii_xpoint #(.DATA_W(DW)) u_b2b_mii_xpoint (
    .a_txd(a_txd), .a_tx_en(a_tx_en), .a_tx_er(a_tx_er),
    .a_pwr_dn(a_pwr_dn), .a_isolate(a_isolate),
    .a_loopback(a_loopback), .a_col_test(a_col_test),
    .b_txd(b_txd), .b_tx_en(b_tx_en), .b_tx_er(b_tx_er),
    .b_pwr_dn(b_pwr_dn), .b_isolate(b_isolate),
    .b_loopback(b_loopback), .b_col_test(b_col_test),
    .a_rxd(a_rxd), .a_rx_dv(a_rx_dv), .a_rx_er(a_rx_er),
    .a_crs(a_crs), .a_col(a_col),
    .b_rxd(b_rxd), .b_rx_dv(b_rx_dv), .b_rx_er(b_rx_er),
    .b_crs(b_crs), .b_col(b_col), .link_down(link_down)
  );

  task automatic chk(input string req, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference routing, mode vector m = {b_pd,b_iso,b_lb,b_ct,a_pd,a_iso,a_lb,a_ct}
  function automatic logic [BW-1:0] ref_rx(input logic [7:0] m,
      input logic [BW-1:0] own, input logic [BW-1:0] peer);
    logic kill, loop, ctst;
    kill = m[7] | m[6] | m[3] | m[2];
    loop = m[5] | m[1];
    ctst = m[4] | m[0];
    if (kill)      return '0;
    else if (loop) return own;
    else if (ctst) return '0;
    else           return peer;
  endfunction

  function automatic string rx_req(input logic [7:0] m);
    if (m[7] | m[6] | m[3] | m[2]) return "R2";
    if (m[5] | m[1])               return "R3";
    if (m[4] | m[0])               return "R4";
    return "R1";
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [BW-1:0] ta, tb, ea, eb;
    logic ld_e;
    {a_txd, a_tx_en, a_tx_er, b_txd, b_tx_en, b_tx_er} = '0;
    {a_pwr_dn, a_isolate, a_loopback, a_col_test} = '0;
    {b_pwr_dn, b_isolate, b_loopback, b_col_test} = '0;
    @(negedge clk);
    // Idle start state: no modes, no traffic
    chk("R5", "link_down idle", BW'(link_down), BW'(0));
    chk("R7", "crs idle", BW'({a_crs, b_crs}), BW'(0));
    chk("R1", "rx idle", BW'({a_rx_er, a_rx_dv, a_rxd}), BW'(0));

    for (int m = 0; m < 256; m++) begin
      for (int t = 0; t < 16; t++) begin
        ta = BW'((t * 13 + 7) & 63);
        tb = BW'((t * 29 + 50) & 63);
        @(negedge clk);
        {a_tx_er, a_tx_en, a_txd} = ta;
        {b_tx_er, b_tx_en, b_txd} = tb;
        {b_pwr_dn, b_isolate, b_loopback, b_col_test,
         a_pwr_dn, a_isolate, a_loopback, a_col_test} = 8'(m);
        @(posedge clk);   // R9: read half a cycle later, no edge needed
        ea   = ref_rx(8'(m), ta, tb);
        eb   = ref_rx(8'(m), tb, ta);
        ld_e = (m != 0);
        chk(rx_req(8'(m)), "side A rx", {a_rx_er, a_rx_dv, a_rxd}, ea);
        chk(rx_req(8'(m)), "side B rx", {b_rx_er, b_rx_dv, b_rxd}, eb);
        chk("R5", "link_down", BW'(link_down), BW'(ld_e));
        chk(ld_e ? "R6" : "R7", "side A crs", BW'(a_crs),
            BW'(ld_e | ta[DW]));
        chk(ld_e ? "R6" : "R7", "side B crs", BW'(b_crs),
            BW'(ld_e | tb[DW]));
        chk("R8", "side A col", BW'(a_col), BW'(m[0]));
        chk("R8", "side B col", BW'(b_col), BW'(m[4]));
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule